// File: doc/BRIEF.md
# Software Trap Entry and Return Sequencer

This block picks the next program counter of a load/store core when software traps and returns from a trap. Each cycle it looks at the instruction word being executed and the address of that instruction. If the top byte of the word matches the trap opcode, the core is sent to one fixed entry address shared by every software trap. On the same clock edge, the address of the following instruction is written into a link register rather than pushed to memory. The low 24 bits of the word are also kept in a register of their own, so one handler can tell up to 2^24 services apart and find each one's parameter table.

A return strobe sends the core back to the address held in the link register. Any other instruction goes on to the next sequential word. The trap entry address lies in the vector area that starts at address zero. Choosing the service routine is left to software.

Top module: `swi_vector_entry`

## Requirements
- R1: While rst_ni is low, link_o and swi_num_o are 0.
- R2: An instruction whose bits [31:24] equal the trap opcode (default 0xEF) is a trap. In that cycle next_pc_o is the shared entry address 0x00000008, whatever the immediate field holds.
- R3: On the clock edge where a trap is present, link_o takes pc_i + 4, computed modulo 2^32 (a trap at 0xFFFFFFFC saves 0x00000000).
- R4: On the clock edge where a trap is present, swi_num_o takes bits [23:0] of the instruction.
- R5: With no trap and ret_i low, next_pc_o is pc_i + 4 modulo 2^32. This holds for all 255 non-matching values of bits [31:24].
- R6: With no trap and ret_i high, next_pc_o equals the current link_o.
- R7: When a trap and ret_i occur in the same cycle, the trap wins: next_pc_o is 0x00000008, and link_o and swi_num_o load as in R3 and R4.
- R8: On an edge with no trap, link_o and swi_num_o keep their values. A return does not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_i | input | 32 | Instruction word being executed |
| pc_i | input | 32 | Address of instr_i |
| ret_i | input | 1 | Return-from-trap strobe |
| next_pc_o | output | 32 | Next program counter |
| link_o | output | 32 | Saved return address |
| swi_num_o | output | 24 | Captured trap number |

## Verification
Assertions check on every cycle that the next-PC choice follows the priority trap > return > sequential. They also check that the link and number registers load exactly on trap edges and hold on every other edge. Whether the opcode match is exact across all 256 top-byte values is shown only by the bench sweep. The same holds for the wrap of the return address at the top of memory and for the return going to the most recently saved address after a series of traps.

// File: rtl/swi_pkg.sv
package swi_pkg;
  typedef enum logic [1:0] {
    SRC_SEQ  = 2'd0,
    SRC_VEC  = 2'd1,
    SRC_LINK = 2'd2
  } pc_src_e;
endpackage

// File: rtl/swi_decode.sv
module swi_decode #(
  parameter int XLEN  = 32,
  parameter int OPC_W = 8,
  parameter int IMM_W = XLEN - OPC_W,
  parameter logic [OPC_W-1:0] SWI_OPC = 8'hEF
) (
  input  logic [XLEN-1:0]  instr_i,
  input  logic             ret_i,
  output logic             trap_o,
  output logic [IMM_W-1:0] imm_o,
  output swi_pkg::pc_src_e src_o
);
  logic [OPC_W-1:0] opc;

  assign opc    = instr_i[XLEN-1 -: OPC_W];
  assign imm_o  = instr_i[IMM_W-1:0];
  assign trap_o = (opc == SWI_OPC);

  // trap outranks return
  always_comb begin
    if (trap_o)     src_o = swi_pkg::SRC_VEC;
    else if (ret_i) src_o = swi_pkg::SRC_LINK;
    else            src_o = swi_pkg::SRC_SEQ;
  end
endmodule

// File: rtl/swi_link_reg.sv
module swi_link_reg #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [XLEN-1:0]  ret_addr_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [XLEN-1:0]  link_o,
  output logic [IMM_W-1:0] num_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_o <= '0;
      num_o  <= '0;
    end else if (ld_i) begin
      link_o <= ret_addr_i;
      num_o  <= imm_i;
    end
  end

  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_val_chk: assert (link_o == '0 && num_o == '0 || $time == 0);
    end
  end

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> ($stable(link_o) && $stable(num_o)));
endmodule

// File: rtl/swi_pc_sel.sv
module swi_pc_sel #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] VEC_ADDR = 32'h0000_0008
) (
  input  swi_pkg::pc_src_e src_i,
  input  logic [XLEN-1:0]  seq_pc_i,
  input  logic [XLEN-1:0]  link_i,
  output logic [XLEN-1:0]  next_pc_o
);
  always_comb begin
    unique case (src_i)
      swi_pkg::SRC_VEC:  next_pc_o = VEC_ADDR;
      swi_pkg::SRC_LINK: next_pc_o = link_i;
      default:           next_pc_o = seq_pc_i;
    endcase
  end
endmodule

// File: rtl/swi_vector_entry.sv
module swi_vector_entry #(
  parameter int XLEN  = 32,
  parameter int OPC_W = 8,
  parameter int STEP  = 4,
  parameter logic [OPC_W-1:0] SWI_OPC = 8'hEF,
  parameter logic [XLEN-1:0] VEC_ADDR = 32'h0000_0008
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [XLEN-1:0]       instr_i,
  input  logic [XLEN-1:0]       pc_i,
  input  logic                  ret_i,
  output logic [XLEN-1:0]       next_pc_o,
  output logic [XLEN-1:0]       link_o,
  output logic [XLEN-OPC_W-1:0] swi_num_o
);
  localparam int IMM_W = XLEN - OPC_W;
  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  logic             trap;
  logic [IMM_W-1:0] imm;
  logic [XLEN-1:0]  seq_pc;
  swi_pkg::pc_src_e src;

  assign seq_pc = pc_i + STEP_V;

  swi_decode #(
    .XLEN(XLEN), .OPC_W(OPC_W), .IMM_W(IMM_W), .SWI_OPC(SWI_OPC)
  ) u_dec (
    .instr_i(instr_i), .ret_i(ret_i), .trap_o(trap), .imm_o(imm), .src_o(src)
  );

  swi_link_reg #(.XLEN(XLEN), .IMM_W(IMM_W)) u_link (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(trap), .ret_addr_i(seq_pc),
    .imm_i(imm), .link_o(link_o), .num_o(swi_num_o)
  );

  swi_pc_sel #(.XLEN(XLEN), .VEC_ADDR(VEC_ADDR)) u_sel (
    .src_i(src), .seq_pc_i(seq_pc), .link_i(link_o), .next_pc_o(next_pc_o)
  );

  // R2 R7
  vec_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[XLEN-1 -: OPC_W] == SWI_OPC) |-> (next_pc_o == VEC_ADDR));

  // R3
  link_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[XLEN-1 -: OPC_W] == SWI_OPC) |=> (link_o == $past(pc_i) + STEP_V));

  // R4
  num_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[XLEN-1 -: OPC_W] == SWI_OPC) |=> (swi_num_o == $past(instr_i[IMM_W-1:0])));

  // R6
  ret_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && instr_i[XLEN-1 -: OPC_W] != SWI_OPC) |-> (next_pc_o == link_o));

  // R5
  seq_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ret_i && instr_i[XLEN-1 -: OPC_W] != SWI_OPC) |-> (next_pc_o == pc_i + STEP_V));
endmodule

// File: tb/swi_vector_entry_tb_top.sv
module swi_vector_entry_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] pc = '0;
  logic        ret = 1'b0;
  logic [31:0] next_pc;
  logic [31:0] link;
  logic [23:0] num;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] exp_link = '0;
  logic [23:0] exp_num = '0;

  always #10 clk = ~clk;

  swi_vector_entry dut_i (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .pc_i(pc), .ret_i(ret),
    .next_pc_o(next_pc), .link_o(link), .swi_num_o(num)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] i_w, input logic [31:0] p, input logic r);
    logic is_trap;
    @(negedge clk);
    instr = i_w; pc = p; ret = r;
    is_trap = (i_w[31:24] == 8'hEF);
    #2;
    if (is_trap)  chk(r ? "R7 vec" : "R2 vec", next_pc, 32'h8);
    else if (r)   chk("R6 ret", next_pc, exp_link);
    else          chk("R5 seq", next_pc, p + 32'd4);
    @(posedge clk);
    if (is_trap) begin
      exp_link = p + 32'd4;
      exp_num  = i_w[23:0];
    end
    #2;
    chk(is_trap ? "R3 link" : "R8 link", link, exp_link);
    chk(is_trap ? "R4 num" : "R8 num", {8'h0, num}, {8'h0, exp_num});
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state, with a trap on the inputs during reset
    instr = 32'hEF12_3456; pc = 32'h100;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 link", link, 32'h0);
    chk("R1 num", {8'h0, num}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    instr = '0;
    // opcode sweep
    for (int op = 0; op < 256; op++) begin
      for (int k = 0; k < 4; k++) begin
        logic [23:0] imm;
        logic [31:0] p;
        imm = 24'(op * 40503 + k * 9973 + 1);
        p = {op[7:0], 8'(k * 37), 14'(op * 3 + k), 2'b00};
        step({op[7:0], imm}, p, k[0]);
      end
    end
    // R3 wrap at top of memory
    step(32'hEF00_0001, 32'hFFFF_FFFC, 1'b0);
    chk("R3 wrap", link, 32'h0);
    step(32'h0000_0000, 32'hFFFF_FFFC, 1'b0);   // R5 wrap
    // R7 trap with return, then return to the newest save
    step(32'hEFFF_FFFF, 32'h0000_4000, 1'b1);
    step(32'hEF00_0000, 32'h0000_5000, 1'b1);
    step(32'hE000_0000, 32'h0000_0008, 1'b1);   // R6 goes to 0x5004
    chk("R6 newest", next_pc, 32'h0000_5004);
    step(32'hEE00_0000, 32'h0000_0010, 1'b1);   // R8 return keeps link
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule